// File: doc/BRIEF.md
# Serial Bus Command Channel Front-End

This block is one command channel of a power-management serial bus master. Software sees a small register window: two write-data registers hold up to eight outgoing bytes, a configuration register names the execution environment the channel belongs to, and writing the command register starts one bus transaction. The command word carries the opcode, target slave, 16-bit register address and byte count. The block hands these fields to a downstream serial engine through a valid/ready request. It then waits for a one-cycle response pulse.

Before anything reaches the bus, the block checks ownership. The target peripheral is identified by the slave id and the upper address byte. The block sends this identifier on a lookup port and compares the returned 3-bit owner with its own environment. A mismatch finishes the command at once with a denial and no request. Results are reported in a sticky status register. For read opcodes, returned bytes land in two read-data registers, and any byte past the requested count is zeroed.

Top module: `sbc_cmd_chan`

## Requirements
- R1: After reset the status register, both read-data registers and both write-data registers read zero, and req_valid is low.
- R2: A launched request carries opcode = command[31:27], slave id = command[23:20], address = command[19:4], count-minus-one = command[2:0], and req_wdata = {write-data 1 (offset 0x14), write-data 0 (offset 0x10)}.
- R3: A command write (offset 0x00) to an idle channel clears status (offset 0x08) to zero. The done bit stays clear until the engine responds.
- R4: On the response, status becomes done (bit 0) plus failure (bit 1) if resp_err was high.
- R5: If the owner returned for the peripheral {slave id, address[15:8]} differs from the environment in config bits 2:0 (offset 0x04), status becomes done+denied (0x5) one cycle after the command write, and no request is raised.
- R6: A command write while a transaction is in flight is ignored: no second request is made. The current transaction completes with the dropped bit (bit 3) set as well.
- R7: For read opcodes, response byte k goes to read-data 0 (0x18) byte k for k<4 and to read-data 1 (0x1C) byte k-4 for k>=4, least significant byte first. Bytes beyond count-minus-one+1 read zero.
- R8: The write-data and config registers read back what was written.
- R9: While req_ready is low, req_valid stays high and all request fields stay stable.
- R10: Only the read opcodes 1, 13 and 15 update the read-data registers. Any other completion leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 5 | Register byte offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational from host_addr) |
| own_ppid | output | 12 | Peripheral id being looked up: {slave id, address[15:8]} |
| own_id | input | 3 | Owner of own_ppid from the ownership table |
| req_valid | output | 1 | Request to the serial engine |
| req_ready | input | 1 | Engine accepts the request |
| req_opcode | output | 5 | Transaction opcode |
| req_sid | output | 4 | Slave id |
| req_addr | output | 16 | Register address |
| req_bc | output | 3 | Byte count minus one |
| req_wdata | output | 64 | Outgoing bytes, byte 0 in bits 7:0 |
| resp_valid | input | 1 | Engine response pulse |
| resp_err | input | 1 | Response reports a bus failure |
| resp_rdata | input | 64 | Returned bytes, byte 0 in bits 7:0 |

## Verification
A command written at clock edge E shows a zeroed status just after E and enters the ownership check. A denial appears in status after E+1, with no request. Otherwise req_valid rises after E+1 and is accepted at the first later edge with req_ready high. Status and read data change at the edge that samples resp_valid. The bench drives inputs on falling edges and reads registers one time unit later. Its request monitor samples two time units after a falling edge and compares each accepted request against the queue the driver filled. A request that arrives with an empty queue counts as a failure.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   localparam int OPC_W  = 5;
   localparam int SID_W  = 4;
   localparam int RA_W   = 16;
   localparam int BC_W   = 3;
   localparam int ST_W   = 4;
   localparam int OFS_W  = 5;

   // command word bit positions
   localparam int CMD_OPC_LSB  = 27;
   localparam int CMD_SID_LSB  = 20;
   localparam int CMD_ADDR_LSB = 4;
   localparam int CMD_BC_LSB   = 0;

   // register offsets
   localparam logic [OFS_W-1:0] OFS_CMD = 5'h00;
   localparam logic [OFS_W-1:0] OFS_CFG = 5'h04;
   localparam logic [OFS_W-1:0] OFS_STS = 5'h08;
   localparam logic [OFS_W-1:0] OFS_WD0 = 5'h10;
   localparam logic [OFS_W-1:0] OFS_WD1 = 5'h14;
   localparam logic [OFS_W-1:0] OFS_RD0 = 5'h18;
   localparam logic [OFS_W-1:0] OFS_RD1 = 5'h1C;

   // status bit indexes
   localparam int ST_DONE = 0;
   localparam int ST_FAIL = 1;
   localparam int ST_DENY = 2;
   localparam int ST_DROP = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_XWR_LONG = 5'd0,
      OP_XRD_LONG = 5'd1,
      OP_XWR      = 5'd2,
      OP_RST      = 5'd3,
      OP_SLP      = 5'd4,
      OP_SHDN     = 5'd5,
      OP_WAKE     = 5'd6,
      OP_XRD      = 5'd13,
      OP_WR       = 5'd14,
      OP_RD       = 5'd15,
      OP_ZWR      = 5'd16
   } sbc_op_e;

   typedef struct packed {
      logic [OPC_W-1:0] opc;
      logic [SID_W-1:0] sid;
      logic [RA_W-1:0]  addr;
      logic [BC_W-1:0]  bc;
   } sbc_cmd_t;

   function automatic logic op_returns_data(input logic [OPC_W-1:0] o);
      return (o == OP_XRD_LONG) || (o == OP_XRD) || (o == OP_RD);
   endfunction

endpackage

// File: rtl/sbc_cmd_unpack.sv
module sbc_cmd_unpack
   import sbc_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] word,
   output sbc_cmd_t          cmd
);
   if (WORD_W < CMD_OPC_LSB + OPC_W) begin : g_bad_width
      $error("command word too narrow for opcode field");
   end

   assign cmd.opc  = word[CMD_OPC_LSB  +: OPC_W];
   assign cmd.sid  = word[CMD_SID_LSB  +: SID_W];
   assign cmd.addr = word[CMD_ADDR_LSB +: RA_W];
   assign cmd.bc   = word[CMD_BC_LSB   +: BC_W];
endmodule

// File: rtl/sbc_byte_mask.sv
module sbc_byte_mask #(
   parameter int NBYTES = 8,
   localparam int CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic [8*NBYTES-1:0] din,
   input  logic [CNT_W-1:0]    last_idx,
   output logic [8*NBYTES-1:0] dout
);
   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      assign dout[8*i +: 8] = (CNT_W'(i) <= last_idx) ? din[8*i +: 8] : 8'h00;
   end
endmodule

// File: rtl/sbc_launch_ctl.sv
module sbc_launch_ctl
   import sbc_pkg::*;
#(
   parameter int WD_W        = 64,
   parameter int EE_W        = 3,
   parameter int PPID_W      = 12,
   parameter bit OWNER_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  sbc_cmd_t          cmd_in,
   input  logic [WD_W-1:0]   wdata_in,
   input  logic [EE_W-1:0]   ee,
   output logic [PPID_W-1:0] own_ppid,
   input  logic [EE_W-1:0]   own_id,
   output logic              req_valid,
   input  logic              req_ready,
   output sbc_cmd_t          req_cmd,
   output logic [WD_W-1:0]   req_wdata,
   input  logic              resp_valid,
   input  logic              resp_err,
   output logic [ST_W-1:0]   status,
   output logic              rd_load
);
   localparam int PER_W = PPID_W - SID_W;

   if (PER_W < 1 || PER_W > RA_W) begin : g_bad_ppid
      $error("peripheral id width must cover slave id plus part of the address");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_REQ, ST_WAIT} state_e;

   state_e            state_q;
   sbc_cmd_t          cmd_q;
   logic [WD_W-1:0]   wd_q;
   logic [ST_W-1:0]   status_q;
   logic              drop_q;
   logic              owner_bad;
   logic              busy_hit;
   logic              drop_now;

   assign own_ppid = {cmd_q.sid, cmd_q.addr[RA_W-1 -: PER_W]};

   if (OWNER_CHECK) begin : g_owner
      assign owner_bad = (own_id != ee);
   end else begin : g_no_owner
      assign owner_bad = 1'b0;
   end

   assign busy_hit = cmd_wr && (state_q != ST_IDLE);
   assign drop_now = drop_q || busy_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cmd_q    <= '0;
         wd_q     <= '0;
         status_q <= '0;
         drop_q   <= 1'b0;
      end else begin
         if (busy_hit) drop_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_wr) begin
                  cmd_q    <= cmd_in;
                  wd_q     <= wdata_in;
                  status_q <= '0;
                  drop_q   <= 1'b0;
                  state_q  <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (owner_bad) begin
                  status_q          <= '0;
                  status_q[ST_DONE] <= 1'b1;
                  status_q[ST_DENY] <= 1'b1;
                  status_q[ST_DROP] <= drop_now;
                  state_q           <= ST_IDLE;
               end else begin
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (resp_valid) begin
                  status_q          <= '0;
                  status_q[ST_DONE] <= 1'b1;
                  status_q[ST_FAIL] <= resp_err;
                  status_q[ST_DROP] <= drop_now;
                  state_q           <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid = (state_q == ST_REQ);
   assign req_cmd   = cmd_q;
   assign req_wdata = wd_q;
   assign status    = status_q;
   assign rd_load   = (state_q == ST_WAIT) && resp_valid && op_returns_data(cmd_q.opc);

   // R9: request held while not accepted
   a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_cmd) && $stable(req_wdata)));

   // R3: command into idle channel zeroes status
   a_r3_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && state_q == ST_IDLE) |=> (status == '0));

   // R3/R4: done only rises from a response or from the ownership check
   a_r4_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_DONE]) |-> ($past(resp_valid) || $past(state_q == ST_CHECK)));

   // R5: denied access raises no request and reports done+denied
   a_r5_deny: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHECK && owner_bad) |=> (!req_valid && status[ST_DONE] && status[ST_DENY]));

   // R6: a busy command leaves the captured command untouched
   a_r6_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      busy_hit |=> $stable(cmd_q));

   // R6: completion coinciding with a busy write reports dropped
   a_r6_drop_report: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && resp_valid && cmd_wr) |=> status[ST_DROP]);
endmodule

// File: rtl/sbc_cmd_chan.sv
module sbc_cmd_chan
   import sbc_pkg::*;
#(
   parameter int HOST_W      = 32,
   parameter int EE_W        = 3,
   parameter int PPID_W      = 12,
   parameter bit OWNER_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [4:0]        host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic [11:0]       own_ppid,
   input  logic [2:0]        own_id,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [4:0]        req_opcode,
   output logic [3:0]        req_sid,
   output logic [15:0]       req_addr,
   output logic [2:0]        req_bc,
   output logic [63:0]       req_wdata,
   input  logic              resp_valid,
   input  logic              resp_err,
   input  logic [63:0]       resp_rdata
);
   localparam int NBYTES = 2 * (HOST_W / 8);
   localparam int DW     = 8 * NBYTES;

   if (HOST_W != 32) begin : g_bad_host
      $error("host word must be 32 bits to hold the command layout");
   end
   if (NBYTES != (1 << BC_W)) begin : g_bad_bytes
      $error("byte count field must span both data registers");
   end
   if (EE_W != 3 || PPID_W != 12) begin : g_bad_ids
      $error("port widths fix the environment and peripheral id sizes");
   end

   logic [HOST_W-1:0] wd0_q, wd1_q, rd0_q, rd1_q;
   logic [EE_W-1:0]   cfg_ee_q;
   logic              cmd_wr;
   sbc_cmd_t          cmd_word;
   sbc_cmd_t          req_cmd;
   logic [ST_W-1:0]   status;
   logic              rd_load;
   logic [DW-1:0]     rd_masked;

   assign cmd_wr = host_wr && (host_addr == OFS_CMD);

   sbc_cmd_unpack #(.WORD_W(HOST_W)) u_unpack (
      .word (host_wdata),
      .cmd  (cmd_word)
   );

   sbc_launch_ctl #(
      .WD_W        (DW),
      .EE_W        (EE_W),
      .PPID_W      (PPID_W),
      .OWNER_CHECK (OWNER_CHECK)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .cmd_in     (cmd_word),
      .wdata_in   ({wd1_q, wd0_q}),
      .ee         (cfg_ee_q),
      .own_ppid   (own_ppid),
      .own_id     (own_id),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_cmd    (req_cmd),
      .req_wdata  (req_wdata),
      .resp_valid (resp_valid),
      .resp_err   (resp_err),
      .status     (status),
      .rd_load    (rd_load)
   );

   sbc_byte_mask #(.NBYTES(NBYTES)) u_mask (
      .din      (resp_rdata),
      .last_idx (req_cmd.bc),
      .dout     (rd_masked)
   );

   assign req_opcode = req_cmd.opc;
   assign req_sid    = req_cmd.sid;
   assign req_addr   = req_cmd.addr;
   assign req_bc     = req_cmd.bc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd0_q    <= '0;
         wd1_q    <= '0;
         cfg_ee_q <= '0;
      end else if (host_wr) begin
         if (host_addr == OFS_WD0) wd0_q    <= host_wdata;
         if (host_addr == OFS_WD1) wd1_q    <= host_wdata;
         if (host_addr == OFS_CFG) cfg_ee_q <= host_wdata[EE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd0_q <= '0;
         rd1_q <= '0;
      end else if (rd_load) begin
         rd0_q <= rd_masked[0      +: HOST_W];
         rd1_q <= rd_masked[HOST_W +: HOST_W];
      end
   end

   always_comb begin
      host_rdata = '0;
      unique case (host_addr)
         OFS_CFG: host_rdata = HOST_W'(cfg_ee_q);
         OFS_STS: host_rdata = HOST_W'(status);
         OFS_WD0: host_rdata = wd0_q;
         OFS_WD1: host_rdata = wd1_q;
         OFS_RD0: host_rdata = rd0_q;
         OFS_RD1: host_rdata = rd1_q;
         default: host_rdata = '0;
      endcase
   end

   // R10: read-data registers change only on a data-returning completion
   a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_load |=> ($stable(rd0_q) && $stable(rd1_q)));
endmodule

// File: tb/tb_sbc_cmd_chan.sv
module tb_sbc_cmd_chan;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [11:0] own_ppid;
   logic [2:0]  own_id;
   logic        req_valid;
   logic        req_ready = 1'b1;
   logic [4:0]  req_opcode;
   logic [3:0]  req_sid;
   logic [15:0] req_addr;
   logic [2:0]  req_bc;
   logic [63:0] req_wdata;
   logic        resp_valid = 1'b0;
   logic        resp_err = 1'b0;
   logic [63:0] resp_rdata = '0;

   // ownership table model: owner is slave id bits 2:0
   assign own_id = own_ppid[10:8];

   sbc_cmd_chan dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .own_ppid(own_ppid),
      .own_id(own_id), .req_valid(req_valid), .req_ready(req_ready),
      .req_opcode(req_opcode), .req_sid(req_sid), .req_addr(req_addr),
      .req_bc(req_bc), .req_wdata(req_wdata), .resp_valid(resp_valid),
      .resp_err(resp_err), .resp_rdata(resp_rdata)
   );

   typedef struct {
      logic [4:0]  opc;
      logic [3:0]  sid;
      logic [15:0] addr;
      logic [2:0]  bc;
      logic [63:0] wd;
   } req_t;

   req_t exp_q[$];
   req_t exp_item;
   int   n_chk = 0;
   int   n_fail = 0;
   int   acc_cnt = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: compares every accepted request with the scoreboard queue
   always @(negedge clk) begin
      #2;
      if (rst_n && req_valid && req_ready) begin
         acc_cnt++;
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 unexpected request actual=%0h expected=none", req_opcode);
         end else begin
            exp_item = exp_q.pop_front();
            check("R2 opcode", 64'(req_opcode), 64'(exp_item.opc));
            check("R2 sid",    64'(req_sid),    64'(exp_item.sid));
            check("R2 addr",   64'(req_addr),   64'(exp_item.addr));
            check("R2 bc",     64'(req_bc),     64'(exp_item.bc));
            check("R2 wdata",  req_wdata,       exp_item.wd);
         end
      end
   end

   function automatic logic [31:0] mk_cmd(input logic [4:0] opc, input logic [3:0] sid,
                                          input logic [15:0] addr, input logic [2:0] bc);
      return {opc, 3'b000, sid, addr, 1'b0, bc};
   endfunction

   task automatic host_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic expect_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] v;
      host_read(a, v);
      check(tag, 64'(v), 64'(exp));
   endtask

   task automatic launch(input logic [4:0] opc, input logic [3:0] sid, input logic [15:0] addr,
                         input logic [2:0] bc, input logic [63:0] wd, input bit expect_req);
      req_t it;
      host_write(5'h10, wd[31:0]);
      host_write(5'h14, wd[63:32]);
      if (expect_req) begin
         it.opc = opc; it.sid = sid; it.addr = addr; it.bc = bc; it.wd = wd;
         exp_q.push_back(it);
      end
      host_write(5'h00, mk_cmd(opc, sid, addr, bc));
   endtask

   task automatic wait_acc(input int prev);
      do begin
         @(negedge clk);
         #3;
      end while (acc_cnt == prev);
   endtask

   task automatic respond(input logic err, input logic [63:0] data);
      @(negedge clk);
      resp_valid = 1'b1; resp_err = err; resp_rdata = data;
      @(negedge clk);
      resp_valid = 1'b0; resp_err = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #1 check("R1 req_valid", 64'(req_valid), 64'd0);
      expect_reg("R1 status", 5'h08, 32'h0);
      expect_reg("R1 rd0", 5'h18, 32'h0);
      expect_reg("R1 rd1", 5'h1C, 32'h0);
      expect_reg("R1 wd0", 5'h10, 32'h0);

      // R8: register readback
      host_write(5'h04, 32'h3);
      expect_reg("R8 cfg", 5'h04, 32'h3);
      host_write(5'h10, 32'hCAFE_0001);
      host_write(5'h14, 32'h0BAD_F00D);
      expect_reg("R8 wd0", 5'h10, 32'hCAFE_0001);
      expect_reg("R8 wd1", 5'h14, 32'h0BAD_F00D);

      // R3/R4/R7: read, 3 bytes
      prev = acc_cnt;
      launch(5'd15, 4'd3, 16'h12A4, 3'd2, 64'h0, 1'b1);
      expect_reg("R3 status cleared", 5'h08, 32'h0);
      wait_acc(prev);
      expect_reg("R3 done not early", 5'h08, 32'h0);
      respond(1'b0, 64'h1122_3344_5566_7788);
      expect_reg("R4 done", 5'h08, 32'h1);
      expect_reg("R7 rd0 3 bytes", 5'h18, 32'h0066_7788);
      expect_reg("R7 rd1 3 bytes", 5'h1C, 32'h0);

      // R4/R7: extended read long, 6 bytes, failure
      prev = acc_cnt;
      launch(5'd1, 4'd11, 16'hFF01, 3'd5, 64'h0, 1'b1);
      wait_acc(prev);
      respond(1'b1, 64'h1122_3344_5566_7788);
      expect_reg("R4 done+fail", 5'h08, 32'h3);
      expect_reg("R7 rd0 6 bytes", 5'h18, 32'h5566_7788);
      expect_reg("R7 rd1 6 bytes", 5'h1C, 32'h0000_3344);

      // R7: extended read, 8 bytes
      prev = acc_cnt;
      launch(5'd13, 4'd3, 16'h0400, 3'd7, 64'h0, 1'b1);
      wait_acc(prev);
      respond(1'b0, 64'hA1B2_C3D4_E5F6_0718);
      expect_reg("R7 rd0 8 bytes", 5'h18, 32'hE5F6_0718);
      expect_reg("R7 rd1 8 bytes", 5'h1C, 32'hA1B2_C3D4);

      // R2/R10: write opcode leaves read data alone
      prev = acc_cnt;
      launch(5'd14, 4'd3, 16'h3C10, 3'd6, 64'h0102_0304_0506_0708, 1'b1);
      wait_acc(prev);
      respond(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
      expect_reg("R10 status", 5'h08, 32'h1);
      expect_reg("R10 rd0 kept", 5'h18, 32'hE5F6_0718);
      expect_reg("R10 rd1 kept", 5'h1C, 32'hA1B2_C3D4);

      // R5: wrong owner (slave 4 owned by environment 4, channel is 3)
      launch(5'd15, 4'd4, 16'h2200, 3'd0, 64'h0, 1'b0);
      expect_reg("R5 denied", 5'h08, 32'h5);
      check("R5 no request", 64'(req_valid), 64'd0);
      repeat (3) @(negedge clk);
      #1 check("R5 still no request", 64'(req_valid), 64'd0);
      expect_reg("R5 rd0 kept", 5'h18, 32'hE5F6_0718);

      // R6: command while busy
      prev = acc_cnt;
      launch(5'd1, 4'd3, 16'h5501, 3'd0, 64'h0, 1'b1);
      wait_acc(prev);
      host_write(5'h00, mk_cmd(5'd15, 4'd3, 16'h7777, 3'd7));
      respond(1'b0, 64'h0000_0000_FFFF_FFAB);
      expect_reg("R6 done+dropped", 5'h08, 32'h9);
      expect_reg("R6 first command data", 5'h18, 32'h0000_00AB);
      repeat (3) @(negedge clk);
      #1 check("R6 no second request", 64'(req_valid), 64'd0);

      // R9: engine stalls
      req_ready = 1'b0;
      prev = acc_cnt;
      launch(5'd2, 4'd3, 16'h0910, 3'd1, 64'h0000_0000_0000_BEEF, 1'b1);
      repeat (3) begin
         @(negedge clk);
         #1 check("R9 valid held", 64'(req_valid), 64'd1);
      end
      req_ready = 1'b1;
      wait_acc(prev);
      respond(1'b0, 64'h0);
      expect_reg("R9 completion", 5'h08, 32'h1);

      check("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule